// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside an Ethernet receive path and decides, for every incoming frame, whether that frame is kept or thrown away. It watches the byte stream, gathers the first six bytes (the destination address, first octet first) and compares the address against three sources of acceptance. The first is a small bank of exact-match entries, each switched on by its own control bit. The second is an inclusive address window given by a lower and an upper bound. The third is a switch that lets every group (multicast) address through. The frame passes if any enabled source accepts it.

The byte stream arrives on a valid/ready interface with start-of-frame and last-byte markers. The filter never applies back-pressure: `s_ready` is held high, so every beat presented with `s_valid` high is consumed in that cycle. The upstream side need not stall, and bytes beyond the sixth are only observed for the end-of-frame marker. One verdict pulse per frame is produced on `verdict_valid`, with `verdict_pass` telling keep from drop. Two counters tally kept and dropped frames, and each counts only while its own enable bit is set.

Configuration goes through a plain register port with a write strobe and a combinational read. The register map is: word 0 control (bit 0 window enable, bit 4+N enable of entry N), word 1 general (bit 0 group-address accept), word 2 counter enables (bit 0 pass, bit 1 discard), word 3 window lower bound, word 4 window upper bound, words 8+N exact-match entry N. Addresses occupy bits 47:0 of a 64-bit word, with the first octet in bits 47:40.

Top module: `rdf_filter`

## Requirements
- R1: After reset both counters are zero, `verdict_valid` is low, and every writable configuration word reads back as zero.
- R2: An exact-match entry N (N ≥ 1) whose enable bit (control bit 4+N) is set passes a frame whose destination equals its stored address.
- R3: An entry whose enable bit is clear never causes a pass, even when its address matches.
- R4: Entry 0 holds the broadcast address (all 48 bits one) permanently. Writes to word 8 have no effect on it, it reads as all ones, and a broadcast frame passes whenever control bit 4 is set.
- R5: When control bit 0 is set, a destination D with lower ≤ D ≤ upper passes, where D is compared as an unsigned 48-bit number with the first octet most significant. When control bit 0 is clear, the bounds have no effect.
- R6: With the window enabled, a lower bound of zero and an upper bound of all ones, every complete frame passes.
- R7: When general bit 0 is set, any destination whose first octet has bit 0 set (address bit 40) passes.
- R8: The verdict pulse is high for exactly one cycle, in the cycle after the sixth byte is accepted. Later bytes of the same frame produce no further verdict.
- R9: A frame whose last byte arrives before its sixth byte gets a drop verdict in the cycle after that last byte.
- R10: The pass counter increments by one, the cycle after a pass verdict, only while counter-enable bit 0 is set.
- R11: The discard counter increments by one, the cycle after a drop verdict, only while counter-enable bit 1 is set.
- R12: `s_ready` is always high. Beats that arrive outside a frame, with no start marker since the last frame ended, produce no verdict.
- R13: Address words read back with bits 63:48 zero, whatever was written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream ready, constant one |
| s_sof | input | 1 | Beat is the first byte of a frame |
| s_last | input | 1 | Beat is the last byte of a frame |
| s_data | input | 8 | Stream byte |
| verdict_valid | output | 1 | One-cycle verdict pulse per frame |
| verdict_pass | output | 1 | Frame kept (qualified by verdict_valid) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word index for write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational |
| pass_count | output | CNT_W | Frames kept while counting enabled |
| drop_count | output | CNT_W | Frames dropped while counting enabled |

## Verification
The assertions assume that `s_valid` is low during reset, and that configuration is steady while a frame header is in flight. A verdict follows a valid beat, and a counter step follows a matching verdict, only if the inputs respect those rules. The stimulus drives bytes and register writes on the falling edge, keeps `s_valid` low through reset, and writes configuration only between frames, with idle cycles after each frame. It also marks every multi-byte frame with a start marker, so each frame yields exactly one header.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
  localparam int ADDR_W       = 48;
  localparam int REG_W        = 64;
  localparam int ENTRY_EN_LSB = 4;
  localparam int ENTRY_BASE   = 8;
  localparam int HDR_BYTES    = 6;

  localparam int W_CTRL     = 0;
  localparam int W_GENERAL  = 1;
  localparam int W_CNT_CFG  = 2;
  localparam int W_RANGE_LO = 3;
  localparam int W_RANGE_HI = 4;

  localparam logic [ADDR_W-1:0] BCAST = {ADDR_W{1'b1}};
endpackage

// File: rtl/rdf_regs.sv
module rdf_regs
  import rdf_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int REG_AW      = 5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we,
  input  logic [REG_AW-1:0]                    addr,
  input  logic [REG_W-1:0]                     wdata,
  output logic [REG_W-1:0]                     rdata,
  output logic                                 range_en,
  output logic                                 mcast_en,
  output logic                                 pass_cnt_en,
  output logic                                 drop_cnt_en,
  output logic [NUM_ENTRIES-1:0]               entry_en,
  output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]   entry_addr,
  output logic [ADDR_W-1:0]                    range_lo,
  output logic [ADDR_W-1:0]                    range_hi
);
  localparam int CTRL_W = ENTRY_EN_LSB + NUM_ENTRIES;

  logic [CTRL_W-1:0] ctrl_q;
  logic              gen_q;
  logic [1:0]        cnt_cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      gen_q     <= 1'b0;
      cnt_cfg_q <= '0;
      range_lo  <= '0;
      range_hi  <= '0;
    end else if (we) begin
      case (int'(addr))
        W_CTRL:     ctrl_q    <= wdata[CTRL_W-1:0];
        W_GENERAL:  gen_q     <= wdata[0];
        W_CNT_CFG:  cnt_cfg_q <= wdata[1:0];
        W_RANGE_LO: range_lo  <= wdata[ADDR_W-1:0];
        W_RANGE_HI: range_hi  <= wdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  assign range_en    = ctrl_q[0];
  assign mcast_en    = gen_q;
  assign pass_cnt_en = cnt_cfg_q[0];
  assign drop_cnt_en = cnt_cfg_q[1];
  assign entry_en    = ctrl_q[CTRL_W-1:ENTRY_EN_LSB];

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_entry
    if (n == 0) begin : g_bcast
      assign entry_addr[n] = BCAST;
    end else begin : g_prog
      logic [ADDR_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else if (we && int'(addr) == ENTRY_BASE + n) val_q <= wdata[ADDR_W-1:0];
      end
      assign entry_addr[n] = val_q;
    end
  end

  always_comb begin
    rdata = '0;
    case (int'(addr))
      W_CTRL:     rdata[CTRL_W-1:0] = ctrl_q;
      W_GENERAL:  rdata[0]          = gen_q;
      W_CNT_CFG:  rdata[1:0]        = cnt_cfg_q;
      W_RANGE_LO: rdata[ADDR_W-1:0] = range_lo;
      W_RANGE_HI: rdata[ADDR_W-1:0] = range_hi;
      default: begin
        for (int n = 0; n < NUM_ENTRIES; n++)
          if (int'(addr) == ENTRY_BASE + n) rdata[ADDR_W-1:0] = entry_addr[n];
      end
    endcase
  end
endmodule

// File: rtl/rdf_capture.sv
module rdf_capture
  import rdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_sof,
  input  logic              s_last,
  input  logic [7:0]        s_data,
  output logic              hdr_done,
  output logic              hdr_short,
  output logic [ADDR_W-1:0] hdr_addr
);
  localparam int POS_W = $clog2(HDR_BYTES + 1);
  localparam logic [POS_W-1:0] IDLE = POS_W'(HDR_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(HDR_BYTES - 1);

  logic [POS_W-1:0]    pos_q;
  logic [POS_W-1:0]    pos;
  logic [ADDR_W-9:0]   shift_q;
  logic                in_hdr;

  assign pos       = s_sof ? '0 : pos_q;
  assign in_hdr    = s_valid && (pos < IDLE);
  assign hdr_done  = in_hdr && (pos == LAST_POS);
  assign hdr_short = in_hdr && s_last && (pos < LAST_POS);
  assign hdr_addr  = {shift_q, s_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= IDLE;
      shift_q <= '0;
    end else if (in_hdr) begin
      shift_q <= {shift_q[ADDR_W-17:0], s_data};
      pos_q   <= s_last ? IDLE : pos + 1'b1;
    end
  end
endmodule

// File: rtl/rdf_match.sv
module rdf_match
  import rdf_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic [ADDR_W-1:0]                   dst,
  input  logic [NUM_ENTRIES-1:0]              entry_en,
  input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  entry_addr,
  input  logic                                range_en,
  input  logic [ADDR_W-1:0]                   range_lo,
  input  logic [ADDR_W-1:0]                   range_hi,
  input  logic                                mcast_en,
  output logic                                accept
);
  logic [NUM_ENTRIES-1:0] exact_hit;
  logic                   range_hit;
  logic                   group_hit;

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_cmp
    assign exact_hit[n] = entry_en[n] && (dst == entry_addr[n]);
  end

  assign range_hit = range_en && (dst >= range_lo) && (dst <= range_hi);
  assign group_hit = mcast_en && dst[ADDR_W-8];
  assign accept    = (|exact_hit) || range_hit || group_hit;
endmodule

// File: rtl/rdf_filter.sv
module rdf_filter
  import rdf_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int REG_AW      = 5,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_sof,
  input  logic              s_last,
  input  logic [7:0]        s_data,
  output logic              verdict_valid,
  output logic              verdict_pass,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic [CNT_W-1:0]  pass_count,
  output logic [CNT_W-1:0]  drop_count
);
  logic                               range_en, mcast_en, pass_cnt_en, drop_cnt_en;
  logic [NUM_ENTRIES-1:0]             entry_en;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] entry_addr;
  logic [ADDR_W-1:0]                  range_lo, range_hi, hdr_addr;
  logic                               hdr_done, hdr_short, accept;

  assign s_ready = 1'b1;

  rdf_regs #(.NUM_ENTRIES(NUM_ENTRIES), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .range_en(range_en), .mcast_en(mcast_en),
    .pass_cnt_en(pass_cnt_en), .drop_cnt_en(drop_cnt_en), .entry_en(entry_en),
    .entry_addr(entry_addr), .range_lo(range_lo), .range_hi(range_hi)
  );

  rdf_capture u_cap (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sof(s_sof), .s_last(s_last),
    .s_data(s_data), .hdr_done(hdr_done), .hdr_short(hdr_short), .hdr_addr(hdr_addr)
  );

  rdf_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
    .dst(hdr_addr), .entry_en(entry_en), .entry_addr(entry_addr),
    .range_en(range_en), .range_lo(range_lo), .range_hi(range_hi),
    .mcast_en(mcast_en), .accept(accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      verdict_pass  <= 1'b0;
      pass_count    <= '0;
      drop_count    <= '0;
    end else begin
      verdict_valid <= hdr_done || hdr_short;
      verdict_pass  <= hdr_done && accept;
      if (verdict_valid && verdict_pass && pass_cnt_en)
        pass_count <= pass_count + 1'b1;
      if (verdict_valid && !verdict_pass && drop_cnt_en)
        drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/rdf_checker.sv
module rdf_checker #(
  parameter int REG_AW = 5,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              verdict_valid,
  input logic              verdict_pass,
  input logic [REG_AW-1:0] reg_addr,
  input logic [63:0]       reg_rdata,
  input logic [CNT_W-1:0]  pass_count,
  input logic [CNT_W-1:0]  drop_count
);
  assert_always_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready);

  assert_pass_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_pass |-> verdict_valid);

  assert_verdict_follows_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> $past(s_valid));

  assert_pass_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_count != $past(pass_count)) |->
      (pass_count == $past(pass_count) + 1'b1) && $past(verdict_valid && verdict_pass));

  assert_drop_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |->
      (drop_count == $past(drop_count) + 1'b1) && $past(verdict_valid && !verdict_pass));

  assert_bcast_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) == rdf_pkg::ENTRY_BASE) |-> (reg_rdata == 64'h0000_FFFF_FFFF_FFFF));
endmodule

bind rdf_filter rdf_checker #(.REG_AW(REG_AW), .CNT_W(CNT_W)) u_rdf_checker (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .verdict_valid(verdict_valid), .verdict_pass(verdict_pass),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .pass_count(pass_count), .drop_count(drop_count)
);

// File: tb/tb_rdf_filter.sv
module tb_rdf_filter;
  localparam int NE = 4;
  localparam int AW = 5;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready, verdict_valid, verdict_pass;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic [CW-1:0] pass_count, drop_count;

  int n_cmp = 0, n_bad = 0;
  int exp_pass_cnt = 0, exp_drop_cnt = 0;
  bit cfg_pass_en = 0, cfg_drop_en = 0;

  logic [47:0] ent [NE];
  logic [NE-1:0] cfg_en = '0;
  bit cfg_mcast = 0, cfg_range = 0;
  logic [47:0] cfg_lo = '0, cfg_hi = '0;

  always #10 clk = ~clk;

  rdf_filter #(.NUM_ENTRIES(NE), .REG_AW(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof),
    .s_last(s_last), .s_data(s_data), .verdict_valid(verdict_valid),
    .verdict_pass(verdict_pass), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pass_count(pass_count),
    .drop_count(drop_count)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [63:0] exp, input string req);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic apply_cfg();
    wr(0, 64'({cfg_en, 3'b000, cfg_range}));
    wr(1, 64'(cfg_mcast));
    wr(2, 64'({cfg_drop_en, cfg_pass_en}));
    wr(3, 64'(cfg_lo));
    wr(4, 64'(cfg_hi));
  endtask

  function automatic bit model(input logic [47:0] a);
    bit r = 0;
    for (int k = 0; k < NE; k++) if (cfg_en[k] && a == ent[k]) r = 1;
    if (cfg_range && a >= cfg_lo && a <= cfg_hi) r = 1;
    if (cfg_mcast && a[40]) r = 1;
    return r;
  endfunction

  task automatic send(input logic [47:0] a, input int len, input string req);
    bit ep;
    ep = (len >= 6) && model(a);
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      if (i > 0) begin
        int j = i - 1;
        bit ev = (j == 5) || (j < 5 && j == len - 1);
        check({req, " verdict_valid (R8/R9)"}, 64'(verdict_valid), 64'(ev));
        if (ev) check({req, " verdict_pass"}, 64'(verdict_pass), 64'(ep));
      end
      if (i < len) begin
        s_valid = 1'b1; s_sof = (i == 0); s_last = (i == len - 1);
        s_data = (i < 6) ? a[47-8*i -: 8] : 8'(i * 37);
      end else begin
        s_valid = 1'b0; s_sof = 1'b0; s_last = 1'b0;
      end
    end
    if (ep && cfg_pass_en) exp_pass_cnt++;
    if (!ep && cfg_drop_en) exp_drop_cnt++;
    @(negedge clk); @(negedge clk);
    check("R10 pass counter", 64'(pass_count), 64'(exp_pass_cnt));
    check("R11 discard counter", 64'(drop_count), 64'(exp_drop_cnt));
  endtask

  initial begin
    logic [47:0] tv [6];
    ent[0] = 48'hFFFF_FFFF_FFFF;
    ent[1] = 48'h0200_0000_0011;
    ent[2] = 48'h0200_0000_0022;
    ent[3] = 48'h0300_0000_0033;
    tv[0] = ent[0]; tv[1] = ent[1]; tv[2] = ent[2]; tv[3] = ent[3];
    tv[4] = 48'h0400_0000_0099; tv[5] = 48'h0100_5E00_0001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 verdict_valid", 64'(verdict_valid), 0);
    check("R1 pass_count", 64'(pass_count), 0);
    check("R1 drop_count", 64'(drop_count), 0);
    for (int a = 0; a <= 4; a++) rd(a, 0, "R1 config word");
    for (int a = 9; a < 8 + NE; a++) rd(a, 0, "R1 entry word");
    check("R12 s_ready", 64'(s_ready), 1);

    // R4 entry 0 fixed; R13 upper bits zero
    wr(8, 64'h1234_0000_0000_0000);
    rd(8, 64'h0000_FFFF_FFFF_FFFF, "R4 entry0 read");
    wr(9, 64'hABCD_0000_0000_0011 | 64'h0200_0000_0000);
    rd(9, 64'h0000_0200_0000_0011, "R13 upper bits");
    for (int k = 1; k < NE; k++) wr(8 + k, 64'(ent[k]));
    for (int k = 1; k < NE; k++) rd(8 + k, 64'(ent[k]), "R2 entry readback");

    // R12 stray beats with no start marker
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_sof = 1'b0; s_last = (i == 7); s_data = 8'hFF;
      if (i > 0) check("R12 stray beat verdict", 64'(verdict_valid), 0);
    end
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
    check("R12 stray beat verdict", 64'(verdict_valid), 0);

    // R2 R3 R4 R7 sweep over entry enables and group accept
    cfg_pass_en = 1; cfg_drop_en = 1;
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < (1 << NE); e++) begin
        cfg_en = NE'(e); cfg_mcast = m[0];
        apply_cfg();
        for (int t = 0; t < 6; t++) send(tv[t], 8, "R2/R3/R4/R7 sweep");
      end
    end

    // R5 window boundaries, enabled and disabled
    cfg_en = '0; cfg_mcast = 0;
    cfg_lo = 48'h0200_0000_0100; cfg_hi = 48'h0200_0000_0200;
    for (int r = 0; r < 2; r++) begin
      cfg_range = r[0];
      apply_cfg();
      send(cfg_lo - 1, 7, "R5 below lower");
      send(cfg_lo, 6, "R5 at lower");
      send(cfg_lo + 1, 9, "R5 inside");
      send(cfg_hi, 6, "R5 at upper");
      send(cfg_hi + 1, 8, "R5 above upper");
    end

    // R6 promiscuous window
    cfg_range = 1; cfg_lo = '0; cfg_hi = '1;
    apply_cfg();
    send(48'h0, 6, "R6 zero");
    send(48'hFFFF_FFFF_FFFF, 6, "R6 ones");
    send(48'h0A0B_0C0D_0E0F, 10, "R6 unicast");

    // R9 short frames, lengths 1..5, dropped even in promiscuous mode
    for (int l = 1; l < 6; l++) send(48'hFFFF_FFFF_FFFF, l, "R9 short frame");

    // R10 R11 counter enables off
    cfg_pass_en = 0; cfg_drop_en = 0;
    apply_cfg();
    send(48'h0200_0000_0011, 8, "R10 pass count disabled");
    send(48'hFFFF_FFFF_FFFF, 3, "R11 drop count disabled");
    cfg_pass_en = 0; cfg_drop_en = 1;
    apply_cfg();
    send(48'h0200_0000_0011, 8, "R10 pass off drop on");
    send(48'h0200_0000_0011, 4, "R11 drop on");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule